// File: doc/BRIEF.md
# Dual Byte FIFO with Programmable Trigger Thresholds

This block buffers bytes in both directions of one serial channel. It holds a transmit queue and a receive queue, each 64 bytes deep, and takes its settings from one write-only control byte. The host side pushes transmit bytes and pops receive bytes. The line side pops transmit bytes and pushes receive bytes. Each queue reports how many bytes it holds.

Each direction raises a threshold flag. The transmit flag is set while the transmit occupancy is below a chosen level. The receive flag is set while the receive occupancy exactly matches a chosen level. The two directions choose from different sets of levels. With the enable bit cleared, each direction falls back to a single-byte holding register. Turning the enable bit on or off throws away whatever either direction holds.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, the control byte is zero, `fifoMode` is 0, `dmaModeSel` is 0, both counts and both pop data outputs are 0, `txBelowTrig` is 1 and `rxAtTrig` is 0.
- R2: With control bit 0 set, each queue holds up to 64 bytes in first-in first-out order. A pop registers the head byte onto the pop data output at the clock edge that accepts it.
- R3: A push into a full queue is dropped, and the count stays at its capacity.
- R4: A pop from an empty queue leaves the count at 0, and the pop data output keeps the last byte it showed.
- R5: A write whose bit 0 differs from the current enable state empties both queues at that edge, whichever way bit 0 changes.
- R6: A control write with bit 0 equal to 0 changes no setting other than the enable. Its flush bits are ignored, and so are its threshold and DMA-select bits.
- R7: A control write with bits 0 and 1 both set empties the receive queue and leaves the transmit queue untouched. A flush overrides a push or pop in the same cycle.
- R8: A control write with bits 0 and 2 both set empties the transmit queue and leaves the receive queue untouched.
- R9: Control bits 5:4 select the transmit threshold: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 56. `txBelowTrig` is 1 exactly when `txCount` is less than the selected threshold.
- R10: Control bits 7:6 select the receive threshold: 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60. `rxAtTrig` is 1 exactly when `rxCount` equals the selected threshold.
- R11: Control bits 5:4 are stored only when `featEn` is 1 during the write. Otherwise the transmit threshold keeps its previous value.
- R12: With bit 0 clear, each direction holds at most one byte. A second push is dropped until that byte is popped.
- R13: Control bit 3, written under R6, appears on `dmaModeSel` and does not change either queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Write strobe for the control byte |
| ctlWrData | input | 8 | Control byte value |
| featEn | input | 1 | Unlocks the transmit threshold field |
| txPush | input | 1 | Host pushes a transmit byte |
| txPushData | input | 8 | Transmit byte pushed |
| txPop | input | 1 | Line side pops a transmit byte |
| txPopData | output | 8 | Last transmit byte popped |
| txCount | output | 7 | Transmit occupancy |
| txBelowTrig | output | 1 | Transmit occupancy below its threshold |
| rxPush | input | 1 | Line side pushes a received byte |
| rxPushData | input | 8 | Received byte pushed |
| rxPop | input | 1 | Host pops a received byte |
| rxPopData | output | 8 | Last received byte popped |
| rxCount | output | 7 | Receive occupancy |
| rxAtTrig | output | 1 | Receive occupancy equal to its threshold |
| fifoMode | output | 1 | Stored enable bit |
| dmaModeSel | output | 1 | Stored DMA-select bit |

## Verification
Every result of the block appears one clock edge after the stimulus that causes it. A push, pop or control write presented in one cycle changes the counts, the pop data and the stored settings at the next rising edge. The two threshold flags follow combinationally from those registers, so they also change at that edge. The bench drives inputs on the falling edge and checks counts and flags on the next falling edge. Its pop monitor compares the pop data 2 ns after the rising edge that accepted the pop, well before any further input change.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic fifoOn;
    logic flushTx;
    logic flushRx;
  } fifoStrobe_t;

  function automatic int txThreshold(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 56;
    endcase
  endfunction

  function automatic int rxThreshold(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 56;
      default: return 60;
    endcase
  endfunction

endpackage

// File: rtl/fifo_lane.sv
module fifo_lane #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoOn,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] capNow;
  logic             pushOk, popOk;

  assign capNow = fifoOn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign pushOk = push && !flush && (count < capNow);
  assign popOk  = pop && !flush && (count != '0);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      popData <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk) begin
        rdPtr   <= nextPtr(rdPtr);
        popData <= mem[rdPtr];
      end
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush && count == capNow) |=> count == $past(count));

  assert_empty_pop_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !flush && count == '0) |=> ($stable(popData) && count == '0));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> count == '0);

  assert_holding_limit_R12: assert property (@(posedge clk) disable iff (!rstN)
    !fifoOn |-> count <= CNT_W'(1));

endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import uart_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic             txPush,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  output logic [CNT_W-1:0] txCount,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPop,
  output logic [WIDTH-1:0] rxPopData,
  output logic [CNT_W-1:0] rxCount
);

  fifo_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txLane (
    .clk(clk), .rstN(rstN), .fifoOn(strobe.fifoOn), .flush(strobe.flushTx),
    .push(txPush), .pushData(txPushData), .pop(txPop),
    .popData(txPopData), .count(txCount)
  );

  fifo_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxLane (
    .clk(clk), .rstN(rstN), .fifoOn(strobe.fifoOn), .flush(strobe.flushRx),
    .push(rxPush), .pushData(rxPushData), .pop(rxPop),
    .popData(rxPopData), .count(rxCount)
  );

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  input  logic             featEn,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output fifoStrobe_t      strobe,
  output logic             txBelowTrig,
  output logic             rxAtTrig,
  output logic             dmaModeSel
);

  logic       enReg;
  logic [1:0] txSel, rxSel;
  logic       modeFlip, gatedWr;

  assign modeFlip = ctlWrEn && (ctlWrData[0] != enReg);
  assign gatedWr  = ctlWrEn && ctlWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg      <= 1'b0;
      txSel      <= 2'b00;
      rxSel      <= 2'b00;
      dmaModeSel <= 1'b0;
    end else if (ctlWrEn) begin
      enReg <= ctlWrData[0];
      if (ctlWrData[0]) begin
        dmaModeSel <= ctlWrData[3];
        rxSel      <= ctlWrData[7:6];
        if (featEn) txSel <= ctlWrData[5:4];
      end
    end
  end

  always_comb begin
    strobe.fifoOn  = enReg;
    strobe.flushTx = modeFlip || (gatedWr && ctlWrData[2]);
    strobe.flushRx = modeFlip || (gatedWr && ctlWrData[1]);
  end

  assign txBelowTrig = txCount < CNT_W'(txThreshold(txSel));
  assign rxAtTrig    = rxCount == CNT_W'(rxThreshold(rxSel));

  assert_gated_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !ctlWrData[0]) |=> ($stable(rxSel) && $stable(txSel) && $stable(dmaModeSel)));

  assert_feature_lock_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !featEn) |=> $stable(txSel));

  assert_toggle_flushes_both_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[0] != enReg) |-> (strobe.flushTx && strobe.flushRx));

  assert_no_flush_when_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !ctlWrData[0] && !enReg) |-> (!strobe.flushTx && !strobe.flushRx));

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  input  logic             featEn,
  input  logic             txPush,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  output logic [CNT_W-1:0] txCount,
  output logic             txBelowTrig,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPop,
  output logic [WIDTH-1:0] rxPopData,
  output logic [CNT_W-1:0] rxCount,
  output logic             rxAtTrig,
  output logic             fifoMode,
  output logic             dmaModeSel
);

  fifoStrobe_t strobe;

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .featEn(featEn), .txCount(txCount), .rxCount(rxCount), .strobe(strobe),
    .txBelowTrig(txBelowTrig), .rxAtTrig(rxAtTrig), .dmaModeSel(dmaModeSel)
  );

  fifo_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop),
    .txPopData(txPopData), .txCount(txCount),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop),
    .rxPopData(rxPopData), .rxCount(rxCount)
  );

  assign fifoMode = strobe.fifoOn;

endmodule

// File: tb/uart_fifo_pair_tb.sv
module uart_fifo_pair_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic featEn = 1'b0;
  logic txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txPushData = '0, rxPushData = '0;
  logic [7:0] txPopData, rxPopData;
  logic [6:0] txCount, rxCount;
  logic txBelowTrig, rxAtTrig, fifoMode, dmaModeSel;

  int checks = 0;
  int fails = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] lastTx = 8'h00, lastRx = 8'h00;
  logic modelOn = 1'b0;
  logic monTp, monRp;
  logic [7:0] monExp;

  always #4 clk = ~clk;

  uart_fifo_pair u_dut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .featEn(featEn),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .txCount(txCount), .txBelowTrig(txBelowTrig),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .rxCount(rxCount), .rxAtTrig(rxAtTrig), .fifoMode(fifoMode), .dmaModeSel(dmaModeSel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int capNow();
    return modelOn ? 64 : 1;
  endfunction

  task automatic pushTx(input logic [7:0] d);
    txPush = 1'b1; txPushData = d;
    if (txQ.size() < capNow()) txQ.push_back(d);
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    rxPush = 1'b1; rxPushData = d;
    if (rxQ.size() < capNow()) rxQ.push_back(d);
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic popTx();
    txPop = 1'b1; @(negedge clk); txPop = 1'b0;
  endtask

  task automatic popRx();
    rxPop = 1'b1; @(negedge clk); rxPop = 1'b0;
  endtask

  task automatic pushPopTx(input logic [7:0] d);
    txPush = 1'b1; txPushData = d; txPop = 1'b1;
    if (txQ.size() < capNow()) txQ.push_back(d);
    @(negedge clk);
    txPush = 1'b0; txPop = 1'b0;
  endtask

  task automatic ctlWrite(input logic [7:0] d, input logic fe);
    ctlWrEn = 1'b1; ctlWrData = d; featEn = fe;
    if (d[0] != modelOn) begin txQ.delete(); rxQ.delete(); end
    modelOn = d[0];
    if (d[0] && d[1]) rxQ.delete();
    if (d[0] && d[2]) txQ.delete();
    @(negedge clk);
    ctlWrEn = 1'b0; featEn = 1'b0;
  endtask

  // Scoreboard monitor: pop data is due at the edge that accepts the pop
  always @(posedge clk) begin
    monTp = txPop;
    monRp = rxPop;
    #2;
    if (rstN && monTp) begin
      monExp = (txQ.size() > 0) ? txQ.pop_front() : lastTx;
      lastTx = monExp;
      chk("R2/R4 tx pop data", int'(txPopData), int'(monExp));
    end
    if (rstN && monRp) begin
      monExp = (rxQ.size() > 0) ? rxQ.pop_front() : lastRx;
      lastRx = monExp;
      chk("R2/R4 rx pop data", int'(rxPopData), int'(monExp));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txCount", txCount, 0);
    chk("R1 rxCount", rxCount, 0);
    chk("R1 txBelowTrig", txBelowTrig, 1);
    chk("R1 rxAtTrig", rxAtTrig, 0);
    chk("R1 fifoMode", fifoMode, 0);
    chk("R1 dmaModeSel", dmaModeSel, 0);
    chk("R1 txPopData", txPopData, 0);

    // R12 holding register mode
    pushTx(8'h11);
    pushTx(8'h22);
    chk("R12 tx holds one", txCount, 1);
    popTx();
    chk("R12 tx empty after pop", txCount, 0);

    // R6 / R13 gated write while disabled
    pushRx(8'h33);
    ctlWrite(8'hCA, 1'b0);
    chk("R6 rx not flushed", rxCount, 1);
    chk("R6 dma not written", dmaModeSel, 0);
    chk("R6 still disabled", fifoMode, 0);

    // R5 enabling flushes
    ctlWrite(8'h01, 1'b0);
    chk("R5 enable empties rx", rxCount, 0);
    chk("R5 fifoMode on", fifoMode, 1);

    // R2 ordering with mixed push and pop
    for (int i = 0; i < 10; i++) pushTx(8'hA0 + 8'(i));
    chk("R2 txCount ten", txCount, 10);
    for (int i = 0; i < 5; i++) pushPopTx(8'hB0 + 8'(i));
    chk("R2 txCount steady", txCount, 10);
    for (int i = 0; i < 10; i++) popTx();
    chk("R2 tx drained", txCount, 0);

    // R3 / R10 fill rx, default threshold 8
    for (int i = 0; i < 64; i++) begin
      pushRx(8'(i));
      if (i == 7) chk("R10 rx at 8", rxAtTrig, 1);
      if (i == 8) chk("R10 rx past 8", rxAtTrig, 0);
    end
    pushRx(8'hEE);
    chk("R3 rx full push dropped", rxCount, 64);
    for (int i = 0; i < 64; i++) popRx();
    popRx();
    chk("R4 rx empty pop count", rxCount, 0);
    chk("R4 rx pop data held", rxPopData, 63);

    // R10 other receive codes
    ctlWrite(8'h43, 1'b0);
    for (int i = 0; i < 16; i++) pushRx(8'h40 + 8'(i));
    chk("R10 rx code 01 at 16", rxAtTrig, 1);
    ctlWrite(8'h83, 1'b0);
    for (int i = 0; i < 55; i++) pushRx(8'(i));
    chk("R10 rx code 10 at 55", rxAtTrig, 0);
    pushRx(8'h77);
    chk("R10 rx code 10 at 56", rxAtTrig, 1);
    ctlWrite(8'hC3, 1'b0);
    for (int i = 0; i < 59; i++) pushRx(8'(i));
    chk("R10 rx code 11 at 59", rxAtTrig, 0);
    pushRx(8'h5A);
    chk("R10 rx code 11 at 60", rxAtTrig, 1);

    // R9 / R11 transmit thresholds
    for (int i = 0; i < 7; i++) pushTx(8'h10 + 8'(i));
    chk("R9 tx 7 below 8", txBelowTrig, 1);
    pushTx(8'h17);
    chk("R9 tx 8 not below 8", txBelowTrig, 0);
    ctlWrite(8'hF1, 1'b0);
    chk("R11 locked tx threshold", txBelowTrig, 0);
    ctlWrite(8'hF1, 1'b1);
    chk("R11 unlocked tx code 11", txBelowTrig, 1);
    for (int i = 0; i < 48; i++) pushTx(8'h20 + 8'(i));
    chk("R9 tx 56 not below 56", txBelowTrig, 0);
    popTx();
    chk("R9 tx 55 below 56", txBelowTrig, 1);
    ctlWrite(8'hD1, 1'b1);
    chk("R9 tx code 01", txBelowTrig, 0);
    ctlWrite(8'hE1, 1'b1);
    chk("R9 tx code 10 at 55", txBelowTrig, 0);
    for (int i = 0; i < 24; i++) popTx();
    chk("R9 tx 31 below 32", txBelowTrig, 1);
    chk("R10 rx still at 60", rxAtTrig, 1);

    // R7 / R8 selective flushes
    ctlWrite(8'hC3, 1'b0);
    chk("R7 rx flushed", rxCount, 0);
    chk("R7 tx kept", txCount, 31);
    ctlWrite(8'hC5, 1'b0);
    chk("R8 tx flushed", txCount, 0);
    chk("R8 rx kept", rxCount, 0);
    for (int i = 0; i < 3; i++) pushTx(8'h60 + 8'(i));
    for (int i = 0; i < 2; i++) pushRx(8'h70 + 8'(i));

    // R13 DMA select stored only
    ctlWrite(8'hC9, 1'b0);
    chk("R13 dmaModeSel set", dmaModeSel, 1);
    chk("R13 tx untouched", txCount, 3);
    chk("R13 rx untouched", rxCount, 2);

    // R5 disabling flushes both
    ctlWrite(8'h00, 1'b0);
    chk("R5 disable empties tx", txCount, 0);
    chk("R5 disable empties rx", rxCount, 0);
    chk("R5 fifoMode off", fifoMode, 0);
    chk("R6 dma kept on gated write", dmaModeSel, 1);

    // R12 again on receive side
    pushRx(8'h81);
    pushRx(8'h82);
    chk("R12 rx holds one", rxCount, 1);
    popRx();
    chk("R12 rx empty", rxCount, 0);

    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule